// File: doc/BRIEF.md
# bfloat16 Multiply-Add Processing Element

This block is the arithmetic core of one cell in a systolic matrix engine. On every cycle where the input strobe is high it takes a weight, a multiplicand and a summand, all in bfloat16, and computes weight × multiplicand + summand. The product is rounded to bfloat16 and kept in a dedicated 16-bit register, which is also a block output. The sum is formed from that register and a delayed copy of the summand.

The unit implements a reduced floating-point subset to keep area and logic depth low:
- Truncation is the only rounding mode.
- Denormal values are flushed to zero.
- An all-ones exponent is an ordinary number.
- Overflow saturates to the largest finite value.

The work is split over a fixed two-stage pipeline. The product and its valid flag appear one cycle after the strobe. The sum and its valid flag appear one cycle after that. A new operation may start on every cycle.

Top module: `bf16_mac_pe`

## Requirements
- R1: Words are {sign[15], exponent[14:7] with bias 127, fraction[6:0]}, and a nonzero exponent implies a hidden leading one. Take the 8-bit×8-bit mantissa product. When its bit 15 is set, the fraction is product bits [14:8] and the exponent is ea+eb-127+1. Otherwise the fraction is bits [13:7] and the exponent is ea+eb-127. The sign is the XOR of the operand signs. The result appears on `prod` with `prod_valid` high one cycle after `in_valid` was sampled high.
- R2: `sum` is `prod` plus the summand that was captured with it, and it appears with `sum_valid` high one cycle after `prod_valid`. The operand with the larger {exponent, mantissa} sets the result sign and the starting exponent. Mantissas are added when the signs match and subtracted otherwise. A carry into bit 8 shifts the result right one place, dropping the low bit, and increments the exponent. Otherwise the result is shifted left until bit 7 is set, and the exponent is decremented once per position.
- R3: An operand whose exponent field is zero counts as zero whatever its fraction is. A product with such an operand is 0x0000 or 0x8000, with the sign set to the XOR of the operand signs. Such a summand leaves a nonzero product unchanged in the sum.
- R4: An exponent field of 0xFF is an ordinary finite value, for example 0x7F00 × 0x4000 = 0x7F80.
- R5: A product whose exponent would exceed 255 saturates to 0x7FFF, or to 0xFFFF when negative.
- R6: A product whose exponent would be 0 or below becomes signed zero (sign = XOR of the operand signs).
- R7: The smaller addend's mantissa is shifted right by the exponent difference, and the bits shifted out are lost. A difference of 8 or more removes it entirely. The normalized result is truncated, never rounded.
- R8: A zero mantissa sum, whether from exact cancellation or from two zero operands, gives 0x0000.
- R9: A sum whose exponent would exceed 255 saturates to 0x7FFF or 0xFFFF. A sum whose exponent would be 0 or below becomes a zero that carries the sign of the larger operand.
- R10: The strobe may be high on consecutive cycles, and each operation yields exactly one product and one sum, in order. While a valid flag is low, the matching data output keeps its last value.
- R11: While reset (active low) is held, and in the cycle after it is released, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| weight | input | 16 | bfloat16 weight |
| mcand | input | 16 | bfloat16 multiplicand |
| summand | input | 16 | bfloat16 summand |
| prod_valid | output | 1 | Product register holds a new result |
| prod | output | 16 | Registered bfloat16 product |
| sum_valid | output | 1 | Sum register holds a new result |
| sum | output | 16 | Registered bfloat16 sum |

## Verification
The product of one operation and the sum of the operation before it leave the block in the same cycle whenever strobes come back to back. Bursts of consecutive strobes mixed with idle gaps provoke this overlap. A driver computes both expected words per operation and queues them separately. A monitor pops each stream independently, so a product that is late or a sum that belongs to the wrong operation shows up as a mismatch. The idle cycles between bursts also confirm that each data output holds its value while its flag is low.

// File: rtl/bf16_pkg.sv
package bf16_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 7;
    localparam int MANT_W  = FRAC_W + 1;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_t;

    function automatic fp_t fp_saturate(input logic s);
        fp_t r;
        r.sign = s;
        r.exp  = '1;
        r.frac = '1;
        return r;
    endfunction

    function automatic fp_t fp_zero(input logic s);
        fp_t r;
        r.sign = s;
        r.exp  = '0;
        r.frac = '0;
        return r;
    endfunction
endpackage

// File: rtl/bf16_lzc.sv
module bf16_lzc #(
    parameter int W = 8,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  x,
    output logic [CW-1:0] cnt
);
    logic [W:0] seen;

    assign seen[W] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_scan
        assign seen[i] = seen[i+1] | x[i];
    end

    always_comb begin
        cnt = '0;
        for (int k = 0; k < W; k++) begin
            if (!seen[k]) cnt = cnt + CW'(1);
        end
    end
endmodule

// File: rtl/bf16_mul.sv
module bf16_mul
    import bf16_pkg::*;
(
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output logic [WORD_W-1:0] y_o
);
    localparam int PW = 2 * MANT_W;

    fp_t a, b, y;
    logic [MANT_W-1:0] ma, mb;
    logic [PW-1:0]     p;
    logic              sgn;
    logic              any_zero;
    logic              unused_low_bits;

    assign a        = fp_t'(a_i);
    assign b        = fp_t'(b_i);
    assign ma       = {1'b1, a.frac};
    assign mb       = {1'b1, b.frac};
    assign p        = PW'(ma) * PW'(mb);
    assign sgn      = a.sign ^ b.sign;
    assign any_zero = (a.exp == '0) || (b.exp == '0);
    assign unused_low_bits = ^p[MANT_W-2:0];

    always_comb begin
        int e_i;
        logic [FRAC_W-1:0] frac;
        if (p[PW-1]) begin
            e_i  = int'(a.exp) + int'(b.exp) - BIAS + 1;
            frac = p[PW-2 -: FRAC_W];
        end else begin
            e_i  = int'(a.exp) + int'(b.exp) - BIAS;
            frac = p[PW-3 -: FRAC_W];
        end
        if (any_zero)
            y = fp_zero(sgn);
        else if (e_i > EXP_MAX)
            y = fp_saturate(sgn);
        else if (e_i <= 0)
            y = fp_zero(sgn);
        else
            y = {sgn, EXP_W'(e_i), frac};

        // R3
        mul_zero_chk: assert (!any_zero || (y.exp == '0 && y.frac == '0));
        // R1
        mul_sign_chk: assert (y.sign == (a_i[WORD_W-1] ^ b_i[WORD_W-1]));
    end

    assign y_o = y;
endmodule

// File: rtl/bf16_add.sv
module bf16_add
    import bf16_pkg::*;
(
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output logic [WORD_W-1:0] y_o
);
    localparam int CW = $clog2(MANT_W + 1);

    fp_t a, b, y;
    logic [MANT_W-1:0] ma, mb, m_big, m_small, m_aligned;
    logic [EXP_W-1:0]  e_big, e_small, diff;
    logic              s_big, a_is_big, do_sub;
    logic [MANT_W:0]   raw;
    logic [CW-1:0]     lz;
    logic [MANT_W-1:0] norm;
    logic              unused_norm_msb;

    assign a  = fp_t'(a_i);
    assign b  = fp_t'(b_i);
    assign ma = (a.exp != '0) ? {1'b1, a.frac} : '0;
    assign mb = (b.exp != '0) ? {1'b1, b.frac} : '0;

    assign a_is_big = {a.exp, ma} >= {b.exp, mb};

    always_comb begin
        if (a_is_big) begin
            e_big = a.exp; m_big = ma; s_big = a.sign;
            e_small = b.exp; m_small = mb;
        end else begin
            e_big = b.exp; m_big = mb; s_big = b.sign;
            e_small = a.exp; m_small = ma;
        end
    end

    assign diff      = e_big - e_small;
    assign m_aligned = (diff >= EXP_W'(MANT_W)) ? '0 : (m_small >> diff);
    assign do_sub    = a.sign ^ b.sign;
    assign raw       = do_sub ? ({1'b0, m_big} - {1'b0, m_aligned})
                              : ({1'b0, m_big} + {1'b0, m_aligned});

    bf16_lzc #(.W(MANT_W)) u_lzc (
        .x   (raw[MANT_W-1:0]),
        .cnt (lz)
    );

    assign norm            = raw[MANT_W-1:0] << lz;
    assign unused_norm_msb = norm[MANT_W-1];

    always_comb begin
        int e_i;
        logic [FRAC_W-1:0] frac;
        if (raw[MANT_W]) begin
            e_i  = int'(e_big) + 1;
            frac = raw[MANT_W-1:1];
        end else begin
            e_i  = int'(e_big) - int'(lz);
            frac = norm[FRAC_W-1:0];
        end
        if (raw == '0)
            y = fp_zero(1'b0);
        else if (e_i > EXP_MAX)
            y = fp_saturate(s_big);
        else if (e_i <= 0)
            y = fp_zero(s_big);
        else
            y = {s_big, EXP_W'(e_i), frac};

        // R3
        zero_addend_chk: assert (!(a_i[WORD_W-2 -: EXP_W] == '0 && b_i[WORD_W-2 -: EXP_W] != '0)
                                 || y == b_i);
        // R9
        no_denorm_out_chk: assert (y.exp != '0 || y.frac == '0);
    end

    assign y_o = y;
endmodule

// File: rtl/bf16_mac_pe.sv
module bf16_mac_pe
    import bf16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] weight,
    input  logic [WORD_W-1:0] mcand,
    input  logic [WORD_W-1:0] summand,
    output logic              prod_valid,
    output logic [WORD_W-1:0] prod,
    output logic              sum_valid,
    output logic [WORD_W-1:0] sum
);
    word_t prod_comb, sum_comb;
    word_t prod_q, addend_q, sum_q;
    logic  v1_q, v2_q;

    bf16_mul u_mul (
        .a_i (weight),
        .b_i (mcand),
        .y_o (prod_comb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1_q     <= 1'b0;
            prod_q   <= '0;
            addend_q <= '0;
        end else begin
            v1_q <= in_valid;
            if (in_valid) begin
                prod_q   <= prod_comb;
                addend_q <= summand;
            end
        end
    end

    bf16_add u_add (
        .a_i (prod_q),
        .b_i (addend_q),
        .y_o (sum_comb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v2_q  <= 1'b0;
            sum_q <= '0;
        end else begin
            v2_q <= v1_q;
            if (v1_q) sum_q <= sum_comb;
        end
    end

    assign prod_valid = v1_q;
    assign prod       = prod_q;
    assign sum_valid  = v2_q;
    assign sum        = sum_q;

    // R10
    pipe_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prod_valid |=> sum_valid);
    // R10
    pipe_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |-> $past(prod_valid));
    // R10
    prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(prod));
    // R10
    sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prod_valid |=> $stable(sum));
endmodule

// File: tb/sim_bf16_mac_pe.sv
module sim_bf16_mac_pe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] weight = '0, mcand = '0, summand = '0;
    logic        prod_valid, sum_valid;
    logic [15:0] prod, sum;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit mon_en = 0;

    logic [15:0] qp_val[$], qs_val[$];
    string       qp_tag[$], qs_tag[$];
    logic [15:0] last_prod = '0, last_sum = '0;
    logic [31:0] rs = 32'h1234_5678;

    always #5 clk = ~clk;

    bf16_mac_pe u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .weight(weight), .mcand(mcand), .summand(summand),
        .prod_valid(prod_valid), .prod(prod),
        .sum_valid(sum_valid), .sum(sum)
    );

    function automatic [15:0] mul_ref(input [15:0] a, input [15:0] b);
        int ma, mb, p, e, f;
        bit s;
        s = a[15] ^ b[15];
        if (a[14:7] == 0 || b[14:7] == 0) return {s, 15'd0};
        ma = 128 + int'(a[6:0]);
        mb = 128 + int'(b[6:0]);
        p  = ma * mb;
        e  = int'(a[14:7]) + int'(b[14:7]) - 127;
        if (p >= 32768) begin e = e + 1; f = (p / 256) % 128; end
        else f = (p / 128) % 128;
        if (e > 255) return {s, 15'h7FFF};
        if (e <= 0) return {s, 15'd0};
        return {s, e[7:0], f[6:0]};
    endfunction

    function automatic [15:0] add_ref(input [15:0] a, input [15:0] b);
        int ea, eb, ma, mb, eL, eS, mL, mS, r, e;
        bit sL;
        ea = int'(a[14:7]);
        eb = int'(b[14:7]);
        ma = (ea != 0) ? 128 + int'(a[6:0]) : 0;
        mb = (eb != 0) ? 128 + int'(b[6:0]) : 0;
        if (ea * 256 + ma >= eb * 256 + mb) begin
            eL = ea; mL = ma; sL = a[15]; eS = eb; mS = mb;
        end else begin
            eL = eb; mL = mb; sL = b[15]; eS = ea; mS = ma;
        end
        if (eL - eS >= 8) mS = 0;
        else mS = mS >> (eL - eS);
        r = (a[15] != b[15]) ? mL - mS : mL + mS;
        if (r == 0) return 16'h0000;
        e = eL;
        if (r >= 256) begin r = r / 2; e = e + 1; end
        while (r < 128) begin r = r * 2; e = e - 1; end
        if (e > 255) return {sL, 15'h7FFF};
        if (e <= 0) return {sL, 15'd0};
        return {sL, e[7:0], r[6:0]};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic send(input logic [15:0] w_i, input logic [15:0] m_i,
                        input logic [15:0] s_i, input string tag);
        logic [15:0] p_e;
        p_e = mul_ref(w_i, m_i);
        qp_val.push_back(p_e);
        qp_tag.push_back(tag);
        qs_val.push_back(add_ref(p_e, s_i));
        qs_tag.push_back(tag);
        weight   = w_i;
        mcand    = m_i;
        summand  = s_i;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            if (prod_valid) begin
                if (qp_val.size() == 0) check("R10", "spurious prod_valid", prod, 16'hxxxx);
                else begin
                    last_prod = qp_val.pop_front();
                    check(qp_tag.pop_front(), "prod", prod, last_prod);
                end
            end else check("R10", "prod hold", prod, last_prod);
            if (sum_valid) begin
                if (qs_val.size() == 0) check("R10", "spurious sum_valid", sum, 16'hxxxx);
                else begin
                    last_sum = qs_val.pop_front();
                    check(qs_tag.pop_front(), "sum", sum, last_sum);
                end
            end else check("R10", "sum hold", sum, last_sum);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs zero while reset is held
        check("R11", "prod in reset", prod, 16'h0000);
        check("R11", "sum in reset", sum, 16'h0000);
        check("R11", "valids in reset", {14'd0, prod_valid, sum_valid}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "valids after reset", {14'd0, prod_valid, sum_valid}, 16'h0000);
        check("R11", "prod after reset", prod, 16'h0000);
        mon_en = 1'b1;

        // R1 / R2 basic arithmetic
        send(16'h3F80, 16'h3F80, 16'h3F80, "R1");
        idle(3);
        send(16'h3FC0, 16'h3FC0, 16'h0000, "R1");
        send(16'hC040, 16'h3FA0, 16'h4000, "R1");
        send(16'h4040, 16'h3F80, 16'hBF80, "R2");
        idle(2);
        // R3 zero and denormal operands
        send(16'h0000, 16'h3F80, 16'h0000, "R3");
        send(16'h0001, 16'hBF80, 16'h0042, "R3");
        send(16'h3F80, 16'h3F80, 16'h8005, "R3");
        idle(2);
        // R4 exponent 0xFF is finite
        send(16'h7F00, 16'h4000, 16'h0000, "R4");
        send(16'h7F80, 16'h3F80, 16'h0000, "R4");
        // R5 product saturation
        send(16'h7F80, 16'h4000, 16'h0000, "R5");
        send(16'hFF80, 16'h4000, 16'h0000, "R5");
        // R6 product underflow
        send(16'h0080, 16'h3F00, 16'h0000, "R6");
        send(16'h8080, 16'h3F00, 16'h0000, "R6");
        idle(1);
        // R7 alignment truncation
        send(16'h3F80, 16'h3F80, 16'h3B80, "R7");
        send(16'h3F80, 16'h3F80, 16'h3C00, "R7");
        send(16'h3F80, 16'h3F80, 16'hBC00, "R7");
        // R8 zero sum gives +0
        send(16'h3F80, 16'h3F80, 16'hBF80, "R8");
        send(16'h8000, 16'h3F80, 16'h8000, "R8");
        // R9 sum saturation and underflow
        send(16'h7F80, 16'h3F80, 16'h7FC0, "R9");
        send(16'h8100, 16'h3F80, 16'h00FF, "R9");
        idle(3);

        // R10 back-to-back burst, then mixed gaps with random operands
        for (int i = 0; i < 8; i++) begin
            logic [15:0] w_r, m_r, s_r;
            rnd(); w_r = {rs[31], 8'd120 + 8'(rs[3:0]), rs[10:4]};
            rnd(); m_r = {rs[31], 8'd122 + 8'(rs[3:0]), rs[10:4]};
            rnd(); s_r = {rs[31], 8'd118 + 8'(rs[4:0]), rs[11:5]};
            send(w_r, m_r, s_r, "R10");
        end
        for (int i = 0; i < 60; i++) begin
            logic [15:0] w_r, m_r, s_r;
            rnd(); w_r = rs[15:0];
            m_r = rs[31:16];
            rnd(); s_r = rs[20:5];
            send(w_r, m_r, s_r, "R2");
            if (rs[0]) idle(int'(rs[2:1]));
        end
        idle(4);
        // R10 every operation produced exactly one product and one sum
        check("R10", "products outstanding", 16'(qp_val.size()), 16'd0);
        check("R10", "sums outstanding", 16'(qs_val.size()), 16'd0);
        done = 1;
        summary();
    end
endmodule